// File: doc/BRIEF.md
# ATA Identify Device Scanner

This block is a host-side sequencer that finds out which of the four ATA device positions hold a drive. A single start pulse begins a fixed sweep over two channels with two devices each. For every position the scanner writes the device-select value, writes the identify opcode, and polls the status register. The first status read that shows the busy bit clear decides whether a drive is there. For a drive that is present, it streams the full 256-word identify block out of the data register.

While the words stream in, the scanner keeps only the three text fields: the serial number, the firmware revision and the model name. It swaps the two bytes of each kept word so the characters come out in reading order, and emits each kept word once on a buffer write port. After each position it raises a one-cycle result pulse with the position index and a present flag. After the last position it also raises a one-cycle completion pulse.

Each channel has its own simple register port: a 3-bit register address, a write strobe with an 8-bit write byte, and a read strobe. The read data appears on the cycle after the read strobe and is held until the next read. Only one strobe on one channel is active in any cycle.

Top module: `ata_ident_scanner`

## Requirements
- R1: After a start pulse, the four positions are visited in the order 0, 1, 2, 3. Position p uses channel p[1] and device p[0], so 0 is channel 0 master, 1 is channel 0 slave, 2 is channel 1 master and 3 is channel 1 slave. Each position ends with exactly one `posDone` pulse carrying `posIndex` = p. `scanDone` pulses exactly once per scan, in the same cycle as the `posDone` of position 3.
- R2: Each position begins with a write of 0xA0 (master) or 0xB0 (slave) to register address 6 of its channel. This write comes before that position's command write.
- R3: The identify opcode 0xEC is written to register address 7 of the same channel, and no strobe appears on the other channel.
- R4: Status (address 7) is read repeatedly while bit 7 (busy) is 1. On the first read with bit 7 equal to 0, the device is absent if bit 0 (error) is 1 or bit 3 (data request) is 0. Otherwise it is present. An error with data request set still means absent.
- R5: If the first status read of a position returns 0x00 or 0xFF, the position is absent after that single read.
- R6: If POLL_LIMIT consecutive status reads all show bit 7 set, the position is absent and no further status is read. A device whose status turns ready on read number POLL_LIMIT is still present.
- R7: For a present position, exactly 256 reads of register address 0 are made.
- R8: For a present position, exactly 34 buffer writes occur. Identify words 10..19 go to slots 0..9, words 23..26 to slots 10..13, and words 27..46 to slots 14..33. `bufAddr` = {position[1:0], slot[5:0]}, and `bufData` is the word with its high and low bytes exchanged.
- R9: For an absent position, no data-register read and no buffer write occurs, and the scan moves on to the next position.
- R10: After reset, and while idle after a scan, no strobe, result pulse or buffer write is active. A start pulse during a scan is ignored, and a start pulse after completion runs a new scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a scan |
| ch0Addr | output | 3 | Channel 0 register address |
| ch0Wr | output | 1 | Channel 0 write strobe |
| ch0Rd | output | 1 | Channel 0 read strobe |
| ch0WrData | output | 8 | Channel 0 write byte |
| ch0RdData | input | 16 | Channel 0 read data, valid the cycle after `ch0Rd` |
| ch1Addr | output | 3 | Channel 1 register address |
| ch1Wr | output | 1 | Channel 1 write strobe |
| ch1Rd | output | 1 | Channel 1 read strobe |
| ch1WrData | output | 8 | Channel 1 write byte |
| ch1RdData | input | 16 | Channel 1 read data, valid the cycle after `ch1Rd` |
| posDone | output | 1 | Pulse: one position finished |
| posIndex | output | 2 | Index of the position that finished |
| posPresent | output | 1 | Device found at that position |
| scanDone | output | 1 | Pulse: all four positions finished |
| bufWe | output | 1 | Buffer write strobe for one extracted word |
| bufAddr | output | 8 | Position and slot of the extracted word |
| bufData | output | 16 | Byte-swapped identify word |

## Verification
The bench builds the scanner with POLL_LIMIT = 8 and the default 256-word identify block. With that limit, a drive that never leaves busy is abandoned after eight reads. It also makes both sides of the limit cheap to reach: a drive that turns ready on the eighth read is present, and one that is still busy on the eighth read is absent. The bench's drive models cover floating-bus and all-zero status, error after busy, ready without data request, and normal drives. Mixing these per position shows that the status-read count, the data-read count and the buffer contents are right for each case.

// File: rtl/ata_scan_pkg.sv
package ata_scan_pkg;

  localparam logic [2:0] REG_DATA    = 3'd0;
  localparam logic [2:0] REG_DEVHEAD = 3'd6;
  localparam logic [2:0] REG_CMD     = 3'd7;

  localparam logic [7:0] SEL_MASTER  = 8'hA0;
  localparam logic [7:0] SEL_SLAVE   = 8'hB0;
  localparam logic [7:0] OP_IDENTIFY = 8'hEC;

  localparam int BIT_BUSY = 7;
  localparam int BIT_DREQ = 3;
  localparam int BIT_ERR  = 0;

  // kept text fields of the identify block (word indices)
  localparam int SERIAL_LO = 10;
  localparam int SERIAL_HI = 19;
  localparam int TEXT_LO   = 23;   // firmware revision followed by model
  localparam int TEXT_HI   = 46;
  localparam int TEXT_SLOT = SERIAL_HI - SERIAL_LO + 1;
  localparam int SLOT_COUNT = TEXT_SLOT + TEXT_HI - TEXT_LO + 1;

  typedef struct packed {
    logic       busWr;
    logic       busRd;
    logic [2:0] busAddr;
    logic       selWrite;
    logic       clrPos;
    logic       incPos;
    logic       clrPoll;
    logic       incPoll;
    logic       clrWord;
    logic       incWord;
    logic       capWord;
    logic       setPresent;
    logic       clrPresent;
    logic       report;
  } scan_strobe_t;

  function automatic logic identKept(input int unsigned w);
    return (w >= SERIAL_LO && w <= SERIAL_HI) || (w >= TEXT_LO && w <= TEXT_HI);
  endfunction

  function automatic logic [5:0] identSlot(input int unsigned w);
    if (w <= SERIAL_HI) return 6'(w - SERIAL_LO);
    return 6'(w - TEXT_LO + TEXT_SLOT);
  endfunction

endpackage

// File: rtl/ata_scan_control.sv
module ata_scan_control
  import ata_scan_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [7:0]   statusByte,
  input  logic         firstPoll,
  input  logic         pollExpired,
  input  logic         lastWord,
  input  logic         lastPos,
  output scan_strobe_t strb
);

  typedef enum logic [2:0] {
    S_IDLE, S_SELECT, S_CMD, S_POLL_RD, S_POLL_CHK, S_DATA_RD, S_DATA_CHK, S_NEXT
  } scan_state_t;

  scan_state_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strb      = '0;
    nextState = state;
    case (state)
      S_IDLE: begin
        if (start) begin
          strb.clrPos = 1'b1;
          nextState   = S_SELECT;
        end
      end
      S_SELECT: begin
        strb.busWr      = 1'b1;
        strb.busAddr    = REG_DEVHEAD;
        strb.selWrite   = 1'b1;
        strb.clrPoll    = 1'b1;
        strb.clrWord    = 1'b1;
        strb.clrPresent = 1'b1;
        nextState       = S_CMD;
      end
      S_CMD: begin
        strb.busWr   = 1'b1;
        strb.busAddr = REG_CMD;
        nextState    = S_POLL_RD;
      end
      S_POLL_RD: begin
        strb.busRd   = 1'b1;
        strb.busAddr = REG_CMD;
        nextState    = S_POLL_CHK;
      end
      S_POLL_CHK: begin
        if (firstPoll && (statusByte == 8'h00 || statusByte == 8'hFF)) begin
          nextState = S_NEXT;
        end else if (statusByte[BIT_BUSY]) begin
          if (pollExpired) nextState = S_NEXT;
          else begin
            strb.incPoll = 1'b1;
            nextState    = S_POLL_RD;
          end
        end else if (statusByte[BIT_ERR] || !statusByte[BIT_DREQ]) begin
          nextState = S_NEXT;
        end else begin
          strb.setPresent = 1'b1;
          nextState       = S_DATA_RD;
        end
      end
      S_DATA_RD: begin
        strb.busRd   = 1'b1;
        strb.busAddr = REG_DATA;
        nextState    = S_DATA_CHK;
      end
      S_DATA_CHK: begin
        strb.capWord = 1'b1;
        strb.incWord = 1'b1;
        nextState    = lastWord ? S_NEXT : S_DATA_RD;
      end
      S_NEXT: begin
        strb.report = 1'b1;
        if (lastPos) nextState = S_IDLE;
        else begin
          strb.incPos = 1'b1;
          nextState   = S_SELECT;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  // R2: the command write always follows the select write
  a_r2_select_then_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_SELECT) |=> (state == S_CMD));

  // R1: finishing the last position returns to idle
  a_r1_last_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_NEXT && lastPos) |=> (state == S_IDLE));

  // R10: a start during a scan does not restart it
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (start && state != S_IDLE && state != S_NEXT) |=> (state != S_IDLE));

endmodule

// File: rtl/ata_scan_datapath.sv
module ata_scan_datapath
  import ata_scan_pkg::*;
#(
  parameter int POLL_LIMIT = 1024,
  parameter int ID_WORDS   = 256
)(
  input  logic               clk,
  input  logic               rstN,
  input  scan_strobe_t       strb,
  output logic [1:0][2:0]    chAddr,
  output logic [1:0]         chWr,
  output logic [1:0]         chRd,
  output logic [1:0][7:0]    chWrData,
  input  logic [1:0][15:0]   chRdData,
  output logic [7:0]         statusByte,
  output logic               firstPoll,
  output logic               pollExpired,
  output logic               lastWord,
  output logic               lastPos,
  output logic               posDone,
  output logic [1:0]         posIndex,
  output logic               posPresent,
  output logic               scanDone,
  output logic               bufWe,
  output logic [7:0]         bufAddr,
  output logic [15:0]        bufData
);

  localparam int PCW = $clog2(POLL_LIMIT + 1);
  localparam int WCW = $clog2(ID_WORDS);

  logic [1:0]     pos;
  logic [PCW-1:0] pollCnt;
  logic [WCW-1:0] wordCnt;
  logic           present;
  logic [15:0]    rdWord;
  logic [7:0]     wrByte;

  assign wrByte = strb.selWrite ? (pos[0] ? SEL_SLAVE : SEL_MASTER) : OP_IDENTIFY;
  assign rdWord = chRdData[pos[1]];

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    logic active;
    assign active       = (pos[1] == 1'(ch));
    assign chWr[ch]     = strb.busWr && active;
    assign chRd[ch]     = strb.busRd && active;
    assign chAddr[ch]   = (active && (strb.busWr || strb.busRd)) ? strb.busAddr : 3'd0;
    assign chWrData[ch] = (active && strb.busWr) ? wrByte : 8'd0;
  end

  assign statusByte  = rdWord[7:0];
  assign firstPoll   = (pollCnt == '0);
  assign pollExpired = (pollCnt == PCW'(POLL_LIMIT - 1));
  assign lastWord    = (wordCnt == WCW'(ID_WORDS - 1));
  assign lastPos     = (pos == 2'd3);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos        <= '0;
      pollCnt    <= '0;
      wordCnt    <= '0;
      present    <= 1'b0;
      posDone    <= 1'b0;
      posIndex   <= '0;
      posPresent <= 1'b0;
      scanDone   <= 1'b0;
      bufWe      <= 1'b0;
      bufAddr    <= '0;
      bufData    <= '0;
    end else begin
      if (strb.clrPos)       pos <= '0;
      else if (strb.incPos)  pos <= pos + 2'd1;

      if (strb.clrPoll)      pollCnt <= '0;
      else if (strb.incPoll) pollCnt <= pollCnt + 1'b1;

      if (strb.clrWord)      wordCnt <= '0;
      else if (strb.incWord) wordCnt <= wordCnt + 1'b1;

      if (strb.clrPresent)      present <= 1'b0;
      else if (strb.setPresent) present <= 1'b1;

      posDone  <= strb.report;
      scanDone <= strb.report && lastPos;
      if (strb.report) begin
        posIndex   <= pos;
        posPresent <= present;
      end

      bufWe <= strb.capWord && identKept(32'(wordCnt));
      if (strb.capWord) begin
        bufAddr <= {pos, identSlot(32'(wordCnt))};
        bufData <= {rdWord[7:0], rdWord[15:8]};
      end
    end
  end

  // R6: busy polls never run past the limit
  a_r6_poll_bound: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt < PCW'(POLL_LIMIT));

  // R8: every buffer write lands inside the text slots
  a_r8_slot_range: assert property (@(posedge clk) disable iff (!rstN)
    bufWe |-> (bufAddr[5:0] < 6'(SLOT_COUNT)));

  // R9: data-register reads only for a present device
  a_r9_data_needs_present: assert property (@(posedge clk) disable iff (!rstN)
    (strb.busRd && strb.busAddr == REG_DATA) |-> present);

  // R3: at most one strobe on one channel per cycle
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $countones({chWr, chRd}) <= 1);

endmodule

// File: rtl/ata_ident_scanner.sv
module ata_ident_scanner
  import ata_scan_pkg::*;
#(
  parameter int POLL_LIMIT = 1024,
  parameter int ID_WORDS   = 256
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output logic [2:0]  ch0Addr,
  output logic        ch0Wr,
  output logic        ch0Rd,
  output logic [7:0]  ch0WrData,
  input  logic [15:0] ch0RdData,
  output logic [2:0]  ch1Addr,
  output logic        ch1Wr,
  output logic        ch1Rd,
  output logic [7:0]  ch1WrData,
  input  logic [15:0] ch1RdData,
  output logic        posDone,
  output logic [1:0]  posIndex,
  output logic        posPresent,
  output logic        scanDone,
  output logic        bufWe,
  output logic [7:0]  bufAddr,
  output logic [15:0] bufData
);

  scan_strobe_t     strb;
  logic [1:0][2:0]  chAddr;
  logic [1:0]       chWr, chRd;
  logic [1:0][7:0]  chWrData;
  logic [7:0]       statusByte;
  logic             firstPoll, pollExpired, lastWord, lastPos;

  ata_scan_control u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .statusByte(statusByte), .firstPoll(firstPoll), .pollExpired(pollExpired),
    .lastWord(lastWord), .lastPos(lastPos), .strb(strb)
  );

  ata_scan_datapath #(.POLL_LIMIT(POLL_LIMIT), .ID_WORDS(ID_WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .chAddr(chAddr), .chWr(chWr), .chRd(chRd), .chWrData(chWrData),
    .chRdData({ch1RdData, ch0RdData}),
    .statusByte(statusByte), .firstPoll(firstPoll), .pollExpired(pollExpired),
    .lastWord(lastWord), .lastPos(lastPos),
    .posDone(posDone), .posIndex(posIndex), .posPresent(posPresent),
    .scanDone(scanDone), .bufWe(bufWe), .bufAddr(bufAddr), .bufData(bufData)
  );

  assign ch0Addr   = chAddr[0];
  assign ch1Addr   = chAddr[1];
  assign ch0Wr     = chWr[0];
  assign ch1Wr     = chWr[1];
  assign ch0Rd     = chRd[0];
  assign ch1Rd     = chRd[1];
  assign ch0WrData = chWrData[0];
  assign ch1WrData = chWrData[1];

endmodule

// File: tb/ata_ident_scanner_tb.sv
module ata_ident_scanner_tb;
  localparam int LIM = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [2:0]  ch0Addr, ch1Addr;
  logic        ch0Wr, ch1Wr, ch0Rd, ch1Rd;
  logic [7:0]  ch0WrData, ch1WrData;
  logic [15:0] rdV [2];
  logic        posDone, posPresent, scanDone, bufWe;
  logic [1:0]  posIndex;
  logic [7:0]  bufAddr;
  logic [15:0] bufData;

  always #4 clk = ~clk;

  ata_ident_scanner #(.POLL_LIMIT(LIM)) u_dut (
    .clk(clk), .rstN(rstN), .start(start),
    .ch0Addr(ch0Addr), .ch0Wr(ch0Wr), .ch0Rd(ch0Rd), .ch0WrData(ch0WrData), .ch0RdData(rdV[0]),
    .ch1Addr(ch1Addr), .ch1Wr(ch1Wr), .ch1Rd(ch1Rd), .ch1WrData(ch1WrData), .ch1RdData(rdV[1]),
    .posDone(posDone), .posIndex(posIndex), .posPresent(posPresent), .scanDone(scanDone),
    .bufWe(bufWe), .bufAddr(bufAddr), .bufData(bufData)
  );

  // drive kinds: 0 floating 0xFF, 1 all-zero, 2 normal, 3 error after busy,
  // 4 stuck busy, 5 ready without data request, 6 ready on read LIM, 7 busy for LIM reads
  localparam int SCEN [4][4] = '{'{2,2,2,2}, '{0,1,3,5}, '{6,7,4,2}, '{0,2,3,6}};

  int checks = 0, fails = 0, cyc = 0;
  int kindOf[4];
  int busyLeft[2], wIdx[2];
  logic selDev[2], selSeen[2];
  int statReads[4], dataReads[4], bufWrites[4];
  logic [63:0] slotMask[4];
  int curPos, doneSeen, scanDoneSeen;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int busyFor(input int k);
    case (k)
      2: return 3;
      3: return 2;
      4: return 1000000;
      5: return 1;
      6: return LIM - 1;
      7: return LIM;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] readyStatus(input int k);
    case (k)
      0: return 8'hFF;
      1: return 8'h00;
      3: return 8'h59;
      5: return 8'h50;
      default: return 8'h58;
    endcase
  endfunction

  function automatic bit expPresent(input int k);
    return (k == 2 || k == 6);
  endfunction

  function automatic int expReads(input int k);
    case (k)
      0, 1: return 1;
      2: return 4;
      3: return 3;
      5: return 2;
      default: return LIM;
    endcase
  endfunction

  function automatic logic [15:0] devWord(input int p, input int i);
    return {2'b00, 2'(p), 4'hA, 8'(i)};
  endfunction

  // drive models, two per channel
  always @(posedge clk) begin
    for (int c = 0; c < 2; c++) begin
      logic wr, rd;
      logic [2:0] a;
      logic [7:0] d;
      int p;
      wr = (c == 0) ? ch0Wr : ch1Wr;
      rd = (c == 0) ? ch0Rd : ch1Rd;
      a  = (c == 0) ? ch0Addr : ch1Addr;
      d  = (c == 0) ? ch0WrData : ch1WrData;
      p  = c * 2 + int'(selDev[c]);
      if (wr && a == 3'd6) begin
        chk(c == curPos / 2, "R3", "select channel", c, curPos / 2);
        chk(d == ((curPos % 2) ? 8'hB0 : 8'hA0), "R2", "select byte", d, (curPos % 2) ? 8'hB0 : 8'hA0);
        selDev[c] = d[4];
        selSeen[c] = 1'b1;
      end else if (wr && a == 3'd7) begin
        chk(d == 8'hEC, "R3", "command byte", d, 8'hEC);
        chk(c == curPos / 2, "R3", "command channel", c, curPos / 2);
        chk(selSeen[c], "R2", "select before command", selSeen[c], 1);
        busyLeft[c] = busyFor(kindOf[p]);
        wIdx[c] = 0;
        selSeen[c] = 1'b0;
      end
      if (rd && a == 3'd7) begin
        statReads[p]++;
        if (busyLeft[c] > 0) begin
          rdV[c] <= 16'h0080;
          busyLeft[c]--;
        end else rdV[c] <= {8'h00, readyStatus(kindOf[p])};
      end else if (rd && a == 3'd0) begin
        dataReads[p]++;
        rdV[c] <= devWord(p, wIdx[c]);
        wIdx[c]++;
      end
    end
  end

  // output monitor
  always @(negedge clk) begin
    if (rstN && posDone) begin
      chk(int'(posIndex) == curPos, "R1", "position order", posIndex, curPos);
      chk(posPresent == expPresent(kindOf[posIndex]), "R4", "present flag", posPresent,
          expPresent(kindOf[posIndex]));
      curPos++;
      doneSeen++;
    end
    if (rstN && scanDone) begin
      scanDoneSeen++;
      chk(posDone && doneSeen == 4, "R1", "scan done with last position", doneSeen, 4);
    end
    if (rstN && bufWe) begin
      int p, s, w;
      logic [15:0] e;
      p = int'(bufAddr[7:6]);
      s = int'(bufAddr[5:0]);
      w = (s < 10) ? s + 10 : s + 13;
      e = devWord(p, w);
      chk(bufData == {e[7:0], e[15:8]}, "R8", "swapped word", bufData, {e[7:0], e[15:8]});
      bufWrites[p]++;
      if (s < 64) slotMask[p][s] = 1'b1;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R1 watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic checkIdle(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!(ch0Wr || ch0Rd || ch1Wr || ch1Rd || posDone || scanDone || bufWe), req,
          "idle outputs", {ch0Wr, ch0Rd, ch1Wr, ch1Rd, posDone, scanDone, bufWe}, 0);
    end
  endtask

  task automatic runScan(input int s, input bit midStart);
    for (int p = 0; p < 4; p++) begin
      kindOf[p] = SCEN[s][p];
      statReads[p] = 0; dataReads[p] = 0; bufWrites[p] = 0; slotMask[p] = '0;
    end
    curPos = 0; doneSeen = 0; scanDoneSeen = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int i = 0; i < 20000 && scanDoneSeen == 0; i++) begin
      @(posedge clk);
      if (midStart && i == 50) begin
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
      end
    end
    chk(scanDoneSeen == 1, "R1", "scan completed", scanDoneSeen, 1);
    checkIdle(6, "R10");
    chk(doneSeen == 4, midStart ? "R10" : "R1", "position pulses", doneSeen, 4);
    chk(scanDoneSeen == 1, midStart ? "R10" : "R1", "single scan done", scanDoneSeen, 1);
    for (int p = 0; p < 4; p++) begin
      int k;
      k = kindOf[p];
      chk(statReads[p] == expReads(k),
          (k == 0 || k == 1) ? "R5" : (k == 4 || k >= 6) ? "R6" : "R4",
          "status reads", statReads[p], expReads(k));
      if (expPresent(k)) begin
        chk(dataReads[p] == 256, "R7", "data reads", dataReads[p], 256);
        chk(bufWrites[p] == 34, "R8", "buffer writes", bufWrites[p], 34);
        chk(slotMask[p] == 64'h3_FFFF_FFFF, "R8", "slot coverage", slotMask[p], 64'h3_FFFF_FFFF);
      end else begin
        chk(dataReads[p] == 0, "R9", "data reads absent", dataReads[p], 0);
        chk(bufWrites[p] == 0, "R9", "buffer writes absent", bufWrites[p], 0);
      end
    end
  endtask

  initial begin
    rdV[0] = '0; rdV[1] = '0;
    selDev[0] = 1'b0; selDev[1] = 1'b0;
    selSeen[0] = 1'b0; selSeen[1] = 1'b0;
    busyLeft[0] = 0; busyLeft[1] = 0; wIdx[0] = 0; wIdx[1] = 0;
    curPos = 0; doneSeen = 0; scanDoneSeen = 0;
    for (int p = 0; p < 4; p++) begin
      kindOf[p] = 0; statReads[p] = 0; dataReads[p] = 0; bufWrites[p] = 0; slotMask[p] = '0;
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    checkIdle(4, "R10");                      // reset state
    for (int s = 0; s < 4; s++) runScan(s, 1'b0);   // vector table
    runScan(0, 1'b1);                         // R10: start during a scan ignored, restart after done
    runScan(2, 1'b0);                         // R6 boundary repeated after a restart
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule